// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A purely combinational datapath unit of parameterised width. It takes two operands, A and B, a 4-bit operation select and a carry-in, and returns one result word plus a carry-out. The upper half of the select picks one of four result sources: an arithmetic circuit, a bitwise logic circuit, a one-place right shift of A, or a one-place left shift of A.

The arithmetic circuit is one ripple chain of full adders. Its first input is always A. Its second input is steered per bit by a 4-way multiplexer controlled by the lower half of the select: B, the complement of B, all zeros or all ones. With the carry-in added, this single adder covers add, add with carry, subtract, subtract with borrow, increment, decrement and two forms of transfer. The logic circuit uses a 4-way multiplexer per bit to choose between four bitwise functions. Both shifts fill the vacated bit with 0. The unit is meant to sit between a register file and its write port, so the whole operation takes one clock period of combinational delay.

Top module: `as_unit`

## Requirements
- R1: With sel_i[3:2] = 2'b00, res_o equals (A + Y + cin_i) modulo 2^WIDTH, where Y is chosen by sel_i[1:0]: 2'b00 gives B, 2'b01 gives ~B, 2'b10 gives all zeros, 2'b11 gives all ones.
- R2: With sel_i[3:2] = 2'b00, cout_o equals bit WIDTH of the full-precision sum A + Y + cin_i.
- R3: With sel_i[3:2] other than 2'b00, cout_o is 0.
- R4: With sel_i[3:2] = 2'b01, res_o is A AND B for sel_i[1:0] = 2'b00, A OR B for 2'b01, A XOR B for 2'b10 and ~A for 2'b11.
- R5: With sel_i[3:2] other than 2'b00, cin_i has no effect on res_o or cout_o.
- R6: With sel_i[3:2] = 2'b10, res_o[i] = A[i+1] for i below WIDTH-1 and res_o[WIDTH-1] = 0; sel_i[1:0] has no effect.
- R7: With sel_i[3:2] = 2'b11, res_o[i] = A[i-1] for i above 0 and res_o[0] = 0; sel_i[1:0] has no effect.
- R8: Wrap-around at the operand limits: decrement (sel_i = 4'b0011, cin_i = 0) of zero gives all ones with cout_o = 0, and increment (sel_i = 4'b0010, cin_i = 1) of all ones gives zero with cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sel_i | input | 4 | [3:2] result source, [1:0] operation within the source |
| cin_i | input | 1 | Carry-in to the adder |
| res_o | output | WIDTH | Selected result |
| cout_o | output | 1 | Adder carry-out, 0 outside arithmetic mode |

## Verification
Every one of the 32 select and carry-in combinations is driven with random operands, so each adder input choice is seen with both carry-in values. This separates add from add-with-carry, and subtract from subtract-with-borrow, by exactly one. Directed operands at zero and all ones show the carry leaving the top stage, and whether the decrement and increment wrap. Alternating bit patterns on A show the shift direction and the zero fill. Repeating each non-arithmetic operation with the carry-in flipped shows whether the carry-in leaks into those paths.

// File: rtl/as_pkg.sv
package as_pkg;
  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_SHR   = 2'b10,
    GRP_SHL   = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    Y_B    = 2'b00,
    Y_NB   = 2'b01,
    Y_ZERO = 2'b10,
    Y_ONES = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    L_AND  = 2'b00,
    L_OR   = 2'b01,
    L_XOR  = 2'b10,
    L_NOTA = 2'b11
  } lop_e;
endpackage

// File: rtl/as_full_add.sv
module as_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = x_i ^ y_i;
  assign s_o = p ^ c_i;
  assign c_o = (x_i & y_i) | (p & c_i);
endmodule

// File: rtl/as_arith.sv
module as_arith
  import as_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] y;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // per-bit 4:1 steering of the adder's second input
    always_comb begin
      unique case (ysel_e'(op_i))
        Y_B:     y[i] = b_i[i];
        Y_NB:    y[i] = ~b_i[i];
        Y_ZERO:  y[i] = 1'b0;
        default: y[i] = 1'b1;
      endcase
    end

    as_full_add u_fa (
      .x_i (a_i[i]),
      .y_i (y[i]),
      .c_i (carry[i]),
      .s_o (sum_o[i]),
      .c_o (carry[i+1])
    );
  end

  assign cout_o = carry[WIDTH];

  always_comb begin
    p_ymux_zero_r1: assert (!(op_i == Y_ZERO) || (y == '0))
      else $error("adder y input not zero");
    p_carry_chain_r2: assert ({cout_o, sum_o} ==
                              ({1'b0, a_i} + {1'b0, y} + {{WIDTH{1'b0}}, cin_i}))
      else $error("ripple chain mismatch");
  end
endmodule

// File: rtl/as_logic.sv
module as_logic
  import as_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] f_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (lop_e'(op_i))
        L_AND:   f_o[i] = a_i[i] & b_i[i];
        L_OR:    f_o[i] = a_i[i] | b_i[i];
        L_XOR:   f_o[i] = a_i[i] ^ b_i[i];
        default: f_o[i] = ~a_i[i];
      endcase
    end
  end

  always_comb begin
    p_logic_not_r4: assert (!(op_i == L_NOTA) || ((f_o ^ a_i) == '1))
      else $error("complement path wrong");
  end
endmodule

// File: rtl/as_shift.sv
module as_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] shr_o,
  output logic [WIDTH-1:0] shl_o
);
  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign shr_o[i] = 1'b0;
    end else begin : g_mid_r
      assign shr_o[i] = a_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl_o[i] = 1'b0;
    end else begin : g_mid_l
      assign shl_o[i] = a_i[i-1];
    end
  end
endmodule

// File: rtl/as_unit.sv
module as_unit
  import as_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       sel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  grp_e             grp;
  logic [WIDTH-1:0] arith_res;
  logic             arith_cout;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] shr_res;
  logic [WIDTH-1:0] shl_res;

  assign grp = grp_e'(sel_i[3:2]);

  as_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .op_i   (sel_i[1:0]),
    .cin_i  (cin_i),
    .sum_o  (arith_res),
    .cout_o (arith_cout)
  );

  as_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (sel_i[1:0]),
    .f_o  (logic_res)
  );

  as_shift #(.WIDTH(WIDTH)) u_shift (
    .a_i   (a_i),
    .shr_o (shr_res),
    .shl_o (shl_res)
  );

  always_comb begin
    unique case (grp)
      GRP_ARITH: res_o = arith_res;
      GRP_LOGIC: res_o = logic_res;
      GRP_SHR:   res_o = shr_res;
      default:   res_o = shl_res;
    endcase
  end

  assign cout_o = (grp == GRP_ARITH) & arith_cout;

  always_comb begin
    p_cout_idle_r3: assert ((grp == GRP_ARITH) || !cout_o)
      else $error("carry-out outside arithmetic mode");
    p_shr_fill_r6: assert (!(grp == GRP_SHR) || !res_o[WIDTH-1])
      else $error("right shift fill not zero");
    p_shl_fill_r7: assert (!(grp == GRP_SHL) || !res_o[0])
      else $error("left shift fill not zero");
  end
endmodule

// File: tb/tb_as_unit.sv
module tb_as_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [3:0]   sel_i = '0;
  logic         cin_i = 1'b0;
  logic [W-1:0] res_o;
  logic         cout_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  as_unit #(.WIDTH(W)) dut (
    .a_i(a_i), .b_i(b_i), .sel_i(sel_i), .cin_i(cin_i),
    .res_o(res_o), .cout_o(cout_o)
  );

  // behavioural reference: {cout, result}
  function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                       logic [3:0] s, logic c);
    int unsigned ai = a, bi = b, yi, tot;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: yi = bi;
          2'b01: yi = (2**W - 1) - bi;
          2'b10: yi = 0;
          default: yi = 2**W - 1;
        endcase
        tot = ai + yi + c;
        return tot[W:0];
      end
      2'b01: begin
        case (s[1:0])
          2'b00: return {1'b0, a & b};
          2'b01: return {1'b0, a | b};
          2'b10: return {1'b0, a ^ b};
          default: return {1'b0, ~a};
        endcase
      end
      2'b10: begin
        tot = ai / 2;
        return tot[W:0];
      end
      default: begin
        tot = (ai * 2) % (2**W);
        return tot[W:0];
      end
    endcase
  endfunction

  task automatic check(string req, logic [W:0] got, logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s sel=%b cin=%b a=%h b=%h got=%h exp=%h",
               req, sel_i, cin_i, a_i, b_i, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] s, logic c);
    @(posedge clk);
    a_i = a; b_i = b; sel_i = s; cin_i = c;
    @(negedge clk);
  endtask

  task automatic check_vs_model();
    logic [W:0] e;
    e = model(a_i, b_i, sel_i, cin_i);
    case (sel_i[3:2])
      2'b00: begin
        check("R1", {1'b0, res_o}, {1'b0, e[W-1:0]});
        check("R2", {{W{1'b0}}, cout_o}, {{W{1'b0}}, e[W]});
      end
      2'b01: begin
        check("R4", {1'b0, res_o}, {1'b0, e[W-1:0]});
        check("R3", {{W{1'b0}}, cout_o}, '0);
      end
      2'b10: begin
        check("R6", {1'b0, res_o}, {1'b0, e[W-1:0]});
        check("R3", {{W{1'b0}}, cout_o}, '0);
      end
      default: begin
        check("R7", {1'b0, res_o}, {1'b0, e[W-1:0]});
        check("R3", {{W{1'b0}}, cout_o}, '0);
      end
    endcase
  endtask

  initial begin
    logic [W:0] first;
    // idle state: all-zero inputs select A+B = 0, carry 0
    @(negedge clk);
    check("R1", {cout_o, res_o}, '0);

    // every select/carry-in combination with random operands
    for (int n = 0; n < 40; n++) begin
      for (int s = 0; s < 16; s++) begin
        for (int c = 0; c < 2; c++) begin
          apply(W'($urandom), W'($urandom), 4'(s), 1'(c));
          check_vs_model();
        end
      end
    end

    // R8 limits
    apply('0, 8'h5a, 4'b0011, 1'b0);
    check("R8", {cout_o, res_o}, {1'b0, {W{1'b1}}});
    apply('1, 8'h5a, 4'b0010, 1'b1);
    check("R8", {cout_o, res_o}, {1'b1, {W{1'b0}}});
    apply('1, '1, 4'b0000, 1'b1);
    check("R2", {cout_o, res_o}, {1'b1, {W{1'b1}}});
    apply(8'h3c, 8'h3c, 4'b0001, 1'b1);
    check("R1", {cout_o, res_o}, {1'b1, {W{1'b0}}});

    // R6/R7 alternating patterns, lower select ignored
    for (int s = 0; s < 4; s++) begin
      apply(8'hab, 8'hff, {2'b10, 2'(s)}, 1'b1);
      check("R6", {cout_o, res_o}, {1'b0, 8'h55});
      apply(8'hd5, 8'hff, {2'b11, 2'(s)}, 1'b1);
      check("R7", {cout_o, res_o}, {1'b0, 8'haa});
    end

    // R5 carry-in has no effect outside arithmetic mode
    for (int s = 4; s < 16; s++) begin
      apply(8'h96, 8'h3c, 4'(s), 1'b0);
      first = {cout_o, res_o};
      apply(8'h96, 8'h3c, 4'(s), 1'b1);
      check("R5", {cout_o, res_o}, first);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule